// File: doc/BRIEF.md
# Exclusive Access Reservation Monitor

This block sits between several requesting masters and one single-port memory. It turns paired exclusive-load and exclusive-store requests into atomic read-modify-write sequences. An exclusive load reads an 8-byte block and records a reservation for the requesting master. A later exclusive store commits only while that reservation is still intact. A committed store returns status 0. A refused store writes nothing and returns status 1, and software then retries the whole sequence.

Each master has its own request port with a valid/ready handshake. A fixed-priority arbiter lets one request through per cycle, and the accepted request drives the memory port in that same cycle. The result returns on a shared response bus one cycle later, flagged by a per-master response strobe.

Every address also carries a shared/non-shared attribute. A shared reservation is watched against the writes of other masters. A non-shared one is only a local pending flag.

Top module: `exclusive_monitor`

## Requirements
- R1: Each cycle, at most one request is accepted: the lowest-numbered master with `req_valid` high gets `req_ready`. After the clock edge that accepts it, `rsp_valid` holds exactly that master's bit for one cycle. With no request pending, `req_ready` and the memory enable stay low.
- R2: Command codes are: 0 plain load, 1 plain store, 2 exclusive load, 3 exclusive store, 4 clear reservation. A load or an exclusive load reads the whole 8-byte block (granule, address bits [AW-1:3]), which appears on `rsp_rdata` in the response cycle. An exclusive load replaces any earlier reservation of that master, so a master holds at most one.
- R3: An exclusive store commits only when the master holds a reservation on the same granule with the same shared flag. It then writes memory in its acceptance cycle, returns status 0 and drops the reservation.
- R4: An exclusive store that does not commit raises no memory write or enable and returns status 1. This covers a store with no reservation, a store to a different granule, and a store whose reservation was lost. Any exclusive store drops the master's reservation.
- R5: An exclusive load with `req_shared`=0 sets only a local flag. Writes by other masters leave that flag untouched, and a matching non-shared exclusive store then commits with status 0.
- R6: Size codes 0, 1, 2 and 3 select 1, 2, 4 and 8 bytes. The byte enables start at byte lane `addr[2:0]`. `req_wdata` is lane-aligned, and requests are naturally aligned.
- R7: A clear-reservation command drops the master's reservation, makes no memory access and returns status 0.
- R8: Every memory write (a plain store, or an exclusive store that commits) clears the shared reservations of all other masters on that granule. A master's own plain store leaves its own reservation in place.
- R9: When two masters present exclusive stores to one reserved granule in the same cycle, the lower-numbered master commits with status 0. The other then fails with status 1.
- R10: Reset removes every reservation and every pending response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | NM | Request valid, one bit per master |
| req_ready | output | NM | Request accepted this cycle |
| req_cmd | input | 3*NM | Command code per master |
| req_addr | input | AW*NM | Byte address per master |
| req_size | input | 2*NM | Size code per master |
| req_shared | input | NM | Address is shared |
| req_wdata | input | 64*NM | Lane-aligned store data |
| rsp_valid | output | NM | Response strobe, one-hot |
| rsp_rdata | output | 64 | Read block of the answered request |
| rsp_status | output | 1 | 0 for success, 1 for a refused exclusive store |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW-3 | Memory block index |
| mem_be | output | 8 | Byte enables |
| mem_wdata | output | 64 | Memory write data |
| mem_rdata | input | 64 | Memory read data, one cycle after enable |

## Verification
A reservation that was left set shows up as status 0 with `mem_we` high where the bench expects a refusal. A reservation that was dropped by mistake shows up as status 1 with no write. Either error is visible at the ports in the acceptance cycle of the next exclusive store of that master, and on `rsp_status` one cycle later. A wrong write-back can also hide in memory until a later load of that granule returns a block that differs from the reference image. The random phase therefore keeps traffic on four granules, so that loads revisit written blocks quickly.

// File: rtl/excl_mon_pkg.sv
package excl_mon_pkg;
  localparam int BLK_BYTES = 8;
  localparam int BLK_LSB   = 3;
  localparam int DATA_W    = BLK_BYTES * 8;

  typedef enum logic [2:0] {
    CMD_LOAD  = 3'd0,
    CMD_STORE = 3'd1,
    CMD_LDEX  = 3'd2,
    CMD_STEX  = 3'd3,
    CMD_CLR   = 3'd4
  } xcmd_e;

  function automatic logic [BLK_BYTES-1:0] lane_mask(input logic [1:0] sz,
                                                     input logic [BLK_LSB-1:0] lo);
    logic [BLK_BYTES-1:0] base;
    case (sz)
      2'd0:    base = 8'h01;
      2'd1:    base = 8'h03;
      2'd2:    base = 8'h0F;
      default: base = 8'hFF;
    endcase
    return base << lo;
  endfunction
endpackage

// File: rtl/xm_prio_arb.sv
module xm_prio_arb #(
  parameter int N = 3
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  always_comb begin
    logic found;
    found = 1'b0;
    gnt_o = '0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i] && !found) begin
        gnt_o[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  // R1: one grant at most, master 0 always wins when it asks
  always_comb begin
    if (!$isunknown(req_i)) begin
      a_r1_single_grant: assert ($onehot0(gnt_o));
      a_r1_low_index_wins: assert (!req_i[0] || gnt_o[0]);
    end
  end
endmodule

// File: rtl/xm_resv_slot.sv
module xm_resv_slot #(
  parameter int GW = 29
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_set_i,
  input  logic          ld_shr_i,
  input  logic [GW-1:0] set_gran_i,
  input  logic          own_clr_i,
  input  logic          wr_seen_i,
  input  logic          wr_other_i,
  input  logic [GW-1:0] wr_gran_i,
  output logic          vld_o,
  output logic          shr_o,
  output logic [GW-1:0] gran_o
);
  logic          vld_q, vld_d, shr_q, shr_d, upd_en;
  logic [GW-1:0] gran_q, gran_d;
  logic          snoop_hit;

  always_comb begin
    snoop_hit = wr_seen_i && wr_other_i && vld_q && shr_q && (gran_q == wr_gran_i);
    vld_d  = vld_q;
    shr_d  = shr_q;
    gran_d = gran_q;
    if (ld_set_i) begin
      vld_d  = 1'b1;
      shr_d  = ld_shr_i;
      gran_d = set_gran_i;
    end else if (own_clr_i || snoop_hit) begin
      vld_d = 1'b0;
    end
    upd_en = ld_set_i || own_clr_i || snoop_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      shr_q  <= 1'b0;
      gran_q <= '0;
    end else if (upd_en) begin
      vld_q  <= vld_d;
      shr_q  <= shr_d;
      gran_q <= gran_d;
    end
  end

  assign vld_o  = vld_q;
  assign shr_o  = shr_q;
  assign gran_o = gran_q;

  a_r2_ldex_tags: assert property (@(posedge clk) disable iff (!rst_n)
    ld_set_i |=> (vld_q && gran_q == $past(set_gran_i)));
  a_r7_own_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (own_clr_i && !ld_set_i) |=> !vld_q);
  a_r8_foreign_write_kills: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_seen_i && wr_other_i && shr_q && gran_q == wr_gran_i && !ld_set_i) |=> !vld_q);
endmodule

// File: rtl/exclusive_monitor.sv
module exclusive_monitor
  import excl_mon_pkg::*;
#(
  parameter int NM = 3,
  parameter int AW = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NM-1:0]        req_valid,
  output logic [NM-1:0]        req_ready,
  input  logic [3*NM-1:0]      req_cmd,
  input  logic [AW*NM-1:0]     req_addr,
  input  logic [2*NM-1:0]      req_size,
  input  logic [NM-1:0]        req_shared,
  input  logic [DATA_W*NM-1:0] req_wdata,
  output logic [NM-1:0]        rsp_valid,
  output logic [DATA_W-1:0]    rsp_rdata,
  output logic                 rsp_status,
  output logic                 mem_en,
  output logic                 mem_we,
  output logic [AW-BLK_LSB-1:0] mem_addr,
  output logic [BLK_BYTES-1:0] mem_be,
  output logic [DATA_W-1:0]    mem_wdata,
  input  logic [DATA_W-1:0]    mem_rdata
);
  localparam int GW = AW - BLK_LSB;

  logic [NM-1:0] gnt;
  logic          any_gnt;
  logic [2:0]    sel_cmd_raw;
  xcmd_e         sel_cmd;
  logic [AW-1:0] sel_addr;
  logic [1:0]    sel_size;
  logic          sel_shr;
  logic [DATA_W-1:0] sel_wdata;
  logic          sel_rvld, sel_rshr;
  logic [GW-1:0] sel_rgran, sel_gran;
  logic          stex_ok, do_wr, do_rd;

  logic [NM-1:0] slot_vld, slot_shr;
  logic [GW-1:0] slot_gran [NM];

  logic [NM-1:0] rsp_vld_q;
  logic          stat_q, stat_d;

  xm_prio_arb #(.N(NM)) u_arb (.req_i(req_valid), .gnt_o(gnt));
  assign req_ready = gnt;
  assign any_gnt   = |gnt;

  always_comb begin
    sel_cmd_raw = '0;
    sel_addr    = '0;
    sel_size    = '0;
    sel_shr     = 1'b0;
    sel_wdata   = '0;
    sel_rvld    = 1'b0;
    sel_rshr    = 1'b0;
    sel_rgran   = '0;
    for (int i = 0; i < NM; i++) begin
      if (gnt[i]) begin
        sel_cmd_raw = req_cmd[i*3 +: 3];
        sel_addr    = req_addr[i*AW +: AW];
        sel_size    = req_size[i*2 +: 2];
        sel_shr     = req_shared[i];
        sel_wdata   = req_wdata[i*DATA_W +: DATA_W];
        sel_rvld    = slot_vld[i];
        sel_rshr    = slot_shr[i];
        sel_rgran   = slot_gran[i];
      end
    end
  end

  always_comb begin
    sel_cmd  = xcmd_e'(sel_cmd_raw);
    sel_gran = sel_addr[AW-1:BLK_LSB];
    stex_ok  = sel_rvld && (sel_rgran == sel_gran) && (sel_rshr == sel_shr);
    do_wr    = any_gnt && ((sel_cmd == CMD_STORE) || (sel_cmd == CMD_STEX && stex_ok));
    do_rd    = any_gnt && ((sel_cmd == CMD_LOAD) || (sel_cmd == CMD_LDEX));
    stat_d   = (sel_cmd == CMD_STEX) && !stex_ok;
  end

  assign mem_en    = do_wr || do_rd;
  assign mem_we    = do_wr;
  assign mem_addr  = sel_gran;
  assign mem_be    = lane_mask(sel_size, sel_addr[BLK_LSB-1:0]);
  assign mem_wdata = sel_wdata;

  for (genvar i = 0; i < NM; i++) begin : g_slot
    xm_resv_slot #(.GW(GW)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .ld_set_i  (gnt[i] && sel_cmd == CMD_LDEX),
      .ld_shr_i  (sel_shr),
      .set_gran_i(sel_gran),
      .own_clr_i (gnt[i] && (sel_cmd == CMD_STEX || sel_cmd == CMD_CLR)),
      .wr_seen_i (do_wr),
      .wr_other_i(!gnt[i]),
      .wr_gran_i (sel_gran),
      .vld_o     (slot_vld[i]),
      .shr_o     (slot_shr[i]),
      .gran_o    (slot_gran[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_vld_q <= '0;
      stat_q    <= 1'b0;
    end else begin
      rsp_vld_q <= gnt;
      if (any_gnt) stat_q <= stat_d;
    end
  end

  assign rsp_valid  = rsp_vld_q;
  assign rsp_status = stat_q;
  assign rsp_rdata  = mem_rdata;

  a_r1_onehot_ready: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_ready));
  a_r1_rsp_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_ready) |=> (rsp_valid == $past(req_ready)));
  a_r4_refusal_wrote_nothing: assert property (@(posedge clk) disable iff (!rst_n)
    ((|rsp_valid) && rsp_status) |-> $past(!mem_we));
  a_r7_clear_no_access: assert property (@(posedge clk) disable iff (!rst_n)
    (any_gnt && sel_cmd == CMD_CLR) |-> !mem_en);
endmodule

// File: tb/tb_exclusive_monitor.sv
module tb_exclusive_monitor;
  localparam int NM = 3;
  localparam int AW = 8;
  localparam int GW = AW - 3;
  localparam int DEPTH = 1 << GW;

  logic clk = 1'b0;
  logic rst_n;
  always #2 clk = ~clk;

  logic [NM-1:0]      req_valid, req_ready, req_shared, rsp_valid;
  logic [3*NM-1:0]    req_cmd;
  logic [AW*NM-1:0]   req_addr;
  logic [2*NM-1:0]    req_size;
  logic [64*NM-1:0]   req_wdata;
  logic [63:0]        rsp_rdata, mem_wdata, mem_rdata;
  logic               rsp_status, mem_en, mem_we;
  logic [GW-1:0]      mem_addr;
  logic [7:0]         mem_be;

  exclusive_monitor #(.NM(NM), .AW(AW)) dut (.*);

  logic [63:0] mem [DEPTH];
  always_ff @(posedge clk) begin
    if (mem_en) begin
      mem_rdata <= mem[mem_addr];
      if (mem_we)
        for (int b = 0; b < 8; b++)
          if (mem_be[b]) mem[mem_addr][b*8 +: 8] <= mem_wdata[b*8 +: 8];
    end
  end

  bit          q_v   [NM];
  logic [2:0]  q_cmd [NM];
  logic [AW-1:0] q_adr [NM];
  logic [1:0]  q_sz  [NM];
  bit          q_shr [NM];
  logic [63:0] q_wd  [NM];
  always_comb begin
    for (int i = 0; i < NM; i++) begin
      req_valid[i]          = q_v[i];
      req_cmd[i*3 +: 3]     = q_cmd[i];
      req_addr[i*AW +: AW]  = q_adr[i];
      req_size[i*2 +: 2]    = q_sz[i];
      req_shared[i]         = q_shr[i];
      req_wdata[i*64 +: 64] = q_wd[i];
    end
  end

  logic [63:0] img [DEPTH];
  bit          mv [NM];
  bit          ms [NM];
  logic [GW-1:0] mg [NM];
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] be_of(input logic [1:0] sz, input logic [2:0] lo);
    logic [7:0] m;
    m = (sz == 0) ? 8'h01 : (sz == 1) ? 8'h03 : (sz == 2) ? 8'h0F : 8'hFF;
    return m << lo;
  endfunction

  task automatic setreq(input int m, input logic [2:0] c, input logic [AW-1:0] a,
                        input logic [1:0] sz, input bit sh, input logic [63:0] wd);
    q_v[m] = 1; q_cmd[m] = c; q_adr[m] = a; q_sz[m] = sz; q_shr[m] = sh; q_wd[m] = wd;
  endtask

  // serve every pending request, lowest index first, checking each against the model
  task automatic round(input string tag);
    bit pend;
    pend = 1;
    while (pend) begin
      int m;
      logic [GW-1:0] g;
      logic [7:0] be;
      logic [63:0] exp_rd;
      bit en, we, st, ok;
      #1;
      m = -1;
      for (int i = NM - 1; i >= 0; i--) if (q_v[i]) m = i;
      g = q_adr[m][AW-1:3];
      be = be_of(q_sz[m], q_adr[m][2:0]);
      exp_rd = img[g];
      en = 0; we = 0; st = 0;
      case (q_cmd[m])
        3'd0: en = 1;
        3'd1: begin en = 1; we = 1; end
        3'd2: begin en = 1; mv[m] = 1; mg[m] = g; ms[m] = q_shr[m]; end
        3'd3: begin
          ok = mv[m] && mg[m] == g && ms[m] == q_shr[m];
          mv[m] = 0;
          if (ok) begin en = 1; we = 1; end else st = 1;
        end
        default: mv[m] = 0;
      endcase
      chk(req_ready == NM'(1 << m), "R1", "ready", 64'(req_ready), 64'(1 << m));
      chk(mem_en == en, tag, "mem_en", 64'(mem_en), 64'(en));
      chk(mem_we == we, tag, "mem_we", 64'(mem_we), 64'(we));
      if (we) begin
        chk(mem_be == be, "R6", "mem_be", 64'(mem_be), 64'(be));
        for (int b = 0; b < 8; b++) if (be[b]) img[g][b*8 +: 8] = q_wd[m][b*8 +: 8];
        for (int k = 0; k < NM; k++)
          if (k != m && mv[k] && ms[k] && mg[k] == g) mv[k] = 0;
      end
      @(negedge clk);
      chk(rsp_valid == NM'(1 << m), "R1", "rsp_valid", 64'(rsp_valid), 64'(1 << m));
      chk(rsp_status == st, tag, "status", 64'(rsp_status), 64'(st));
      if (q_cmd[m] == 3'd0 || q_cmd[m] == 3'd2)
        chk(rsp_rdata == exp_rd, "R2", "rdata", rsp_rdata, exp_rd);
      q_v[m] = 0;
      pend = 0;
      for (int i = 0; i < NM; i++) if (q_v[i]) pend = 1;
    end
  endtask

  task automatic one(input int m, input logic [2:0] c, input logic [AW-1:0] a,
                     input logic [1:0] sz, input bit sh, input logic [63:0] wd, input string tag);
    setreq(m, c, a, sz, sh, wd);
    round(tag);
  endtask

  task automatic do_reset();
    rst_n = 0;
    for (int i = 0; i < NM; i++) mv[i] = 0;
    repeat (2) @(negedge clk);
    chk(rsp_valid == 0, "R10", "rsp_valid in reset", 64'(rsp_valid), 0);
    chk(mem_en == 0, "R1", "idle mem_en", 64'(mem_en), 0);
    chk(req_ready == 0, "R1", "idle ready", 64'(req_ready), 0);
    rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < NM; i++) begin
      q_v[i] = 0; q_cmd[i] = 0; q_adr[i] = 0; q_sz[i] = 0; q_shr[i] = 0; q_wd[i] = 0;
    end
    for (int k = 0; k < DEPTH; k++) begin
      mem[k] = {32'(k) * 32'h0101_0101, ~(32'(k) * 32'h1111_1111)};
      img[k] = mem[k];
    end
    do_reset();
    // R2/R3 basic pair
    one(0, 3'd2, 8'h10, 2'd3, 1, 0, "R2");
    one(0, 3'd3, 8'h10, 2'd3, 1, 64'hA5A5_0000_1234_5678, "R3");
    // R4 store without reservation, then read back
    one(1, 3'd3, 8'h10, 2'd3, 1, 64'hDEAD_BEEF_DEAD_BEEF, "R4");
    one(1, 3'd0, 8'h10, 2'd3, 1, 0, "R4");
    // R8 foreign write breaks reservation
    one(0, 3'd2, 8'h18, 2'd3, 1, 0, "R8");
    one(2, 3'd1, 8'h1C, 2'd2, 1, 64'h7777_6666_0000_0000, "R8");
    one(0, 3'd3, 8'h18, 2'd3, 1, 64'h1, "R8");
    // R8 own plain store keeps reservation
    one(0, 3'd2, 8'h20, 2'd3, 1, 0, "R8");
    one(0, 3'd1, 8'h23, 2'd0, 1, 64'h0000_0000_5A00_0000, "R8");
    one(0, 3'd3, 8'h20, 2'd3, 1, 64'h2, "R8");
    // R9 same-cycle exclusive stores
    setreq(0, 3'd2, 8'h28, 2'd3, 1, 0); setreq(1, 3'd2, 8'h28, 2'd3, 1, 0); round("R9");
    setreq(0, 3'd3, 8'h28, 2'd3, 1, 64'h3); setreq(1, 3'd3, 8'h28, 2'd3, 1, 64'h4); round("R9");
    // R2 a second exclusive load replaces the first
    one(2, 3'd2, 8'h10, 2'd3, 1, 0, "R2");
    one(2, 3'd2, 8'h18, 2'd3, 1, 0, "R2");
    one(2, 3'd3, 8'h10, 2'd3, 1, 64'h5, "R2");
    // R4 granule mismatch
    one(1, 3'd2, 8'h30, 2'd3, 1, 0, "R4");
    one(1, 3'd3, 8'h38, 2'd3, 1, 64'h6, "R4");
    // R5 non-shared flag survives a foreign write
    one(2, 3'd2, 8'h30, 2'd3, 0, 0, "R5");
    one(0, 3'd1, 8'h30, 2'd3, 1, 64'h99, "R5");
    one(2, 3'd3, 8'h30, 2'd3, 0, 64'h7, "R5");
    // R7 clear command
    one(1, 3'd2, 8'h10, 2'd3, 1, 0, "R7");
    one(1, 3'd4, 8'h10, 2'd3, 1, 0, "R7");
    one(1, 3'd3, 8'h10, 2'd3, 1, 64'h8, "R7");
    // R6 narrow stores then read back
    one(0, 3'd1, 8'h13, 2'd0, 1, 64'h0000_0000_CC00_0000, "R6");
    one(0, 3'd1, 8'h16, 2'd1, 1, 64'hBBAA_0000_0000_0000, "R6");
    one(0, 3'd1, 8'h10, 2'd2, 1, 64'h0000_0000_0F0E_0D0C, "R6");
    one(1, 3'd0, 8'h10, 2'd3, 1, 0, "R6");
    // R10 reservation lost across reset
    one(0, 3'd2, 8'h08, 2'd3, 1, 0, "R10");
    do_reset();
    one(0, 3'd3, 8'h08, 2'd3, 1, 64'h9, "R10");
    // random mix on four granules
    for (int r = 0; r < 400; r++) begin
      int msk;
      msk = 1 + ($urandom % 7);
      for (int m = 0; m < NM; m++) begin
        if (msk[m]) begin
          int pick;
          logic [2:0] c;
          logic [1:0] sz;
          logic [2:0] lo;
          pick = $urandom % 10;
          c = (pick < 2) ? 3'd0 : (pick < 4) ? 3'd1 : (pick < 6) ? 3'd2 : (pick < 9) ? 3'd3 : 3'd4;
          sz = 2'($urandom % 4);
          lo = 3'($urandom % 8) & ~3'((1 << sz) - 1);
          setreq(m, c, {3'($urandom % 4), lo} + 8'h40, sz, ($urandom % 5) != 0,
                 {$urandom, $urandom});
        end
      end
      round("R3");
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R1 watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule